// File: doc/BRIEF.md
# Beacon Timer Set with Window Checker

This block keeps four wrapping timers that schedule beacon-related events against a time-unit (TU) count supplied from outside. The four timers are the next beacon target, the DMA beacon alert, the software beacon alert and the end of the ATIM window. While timing is enabled, a timer fires when the incoming TU count equals its stored value. When it fires, it moves forward by one beacon interval. A timer that the count jumps past is left behind until the 16-bit count wraps around and meets it again.

Software loads each timer, the interval and the enable bit through a small write port. An arm command derives all four timers from one next-beacon value. A combinational checker watches the two windows that matter for traffic: ATIM end after next beacon, and next beacon after the DMA alert. It flags them when a time jump has stretched either window. The check allows for either timer having already advanced or wrapped.

Top module: `beacon_timer_set`

## Requirements
- R1: While `rst` is high at a clock edge, every timer, the interval and the enable bit clear to zero, and `fire` is all zeros after that edge.
- R2: A write with `wr_en` high loads the value on the next edge. Address 0 loads the next-beacon timer (16 bits), 1 the DMA alert (19 bits), 2 the software alert (19 bits), 3 the ATIM end (16 bits), 4 the interval (16 bits) and 5 the control word (bit 0 = enable). A timer written in a cycle neither advances nor fires in that cycle.
- R3: A write to address 6 takes next beacon NB from `wr_data[15:0]` and loads all four timers in one edge. Next beacon gets NB. ATIM end gets NB+1. DMA alert gets (NB-DMA_MARGIN)<<3. Software alert gets (NB-SW_MARGIN)<<3. Each TU difference wraps modulo 2^16.
- R4: While enabled, a timer whose TU value equals `tu_now` at an edge raises its `fire` bit for exactly the next cycle. The TU value is bits [18:3] for the two alert timers and the whole value for the other two. Bit 0 is next beacon, 1 DMA alert, 2 software alert, 3 ATIM end.
- R5: A timer that fires adds the interval to itself, modulo its width. The two alert timers add the interval shifted left by 3.
- R6: While disabled, no timer fires and unwritten timers hold their values.
- R7: A timer whose TU value is skipped by `tu_now` keeps its value until `tu_now` equals it again.
- R8: A window from A to B of width W with interval I is accepted when any one of four conditions holds: B-A=W; A-B=I-W; (A+65536)-B=I-W when A<65536; (B+65536)-A=W.
- R9: `window_ok` is high exactly when two windows are both accepted: ATIM end relative to next beacon with W=1, and next beacon relative to the DMA alert TU value with W=DMA_MARGIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tu_now | input | 16 | Current time in TU |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0-6) |
| wr_data | input | 19 | Write value |
| fire | output | 4 | One-cycle expiry pulses, one per timer |
| nbt_q | output | 16 | Next beacon timer |
| dma_q | output | 19 | DMA alert timer, 1/8 TU |
| swba_q | output | 19 | Software alert timer, 1/8 TU |
| atim_q | output | 16 | ATIM window end timer |
| window_ok | output | 1 | Both checked windows are consistent |

## Verification
Two functions can meet in one cycle: a software write to a timer, and that same timer's match against `tu_now`. The bench provokes this by writing the next-beacon timer in the very cycle that `tu_now` equals it. It expects the written value and no pulse. Several timers matching together, and jumps, wraps and backward steps of `tu_now`, are swept against an arithmetic model. The window flag is judged after every cycle from the four acceptance conditions.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int TU_W    = 16;
    localparam int FRAC_W  = 3;
    localparam int ALERT_W = TU_W + FRAC_W;
    localparam int SLOTS   = 4;

    localparam int SLOT_NBT  = 0;
    localparam int SLOT_DMA  = 1;
    localparam int SLOT_SWBA = 2;
    localparam int SLOT_ATIM = 3;

    typedef enum logic [2:0] {
        AD_NBT  = 3'd0,
        AD_DMA  = 3'd1,
        AD_SWBA = 3'd2,
        AD_ATIM = 3'd3,
        AD_IVL  = 3'd4,
        AD_CTRL = 3'd5,
        AD_ARM  = 3'd6
    } bt_addr_e;

    // Window from a to b of width w, tolerant of one side having advanced or wrapped
    function automatic logic span_fits(input logic [TU_W-1:0] a, input logic [TU_W-1:0] b,
                                       input int w, input logic [TU_W-1:0] ivl);
        int ai, bi, iv;
        ai = int'({16'd0, a});
        bi = int'({16'd0, b});
        iv = int'({16'd0, ivl});
        return (bi - ai == w) ||
               (ai - bi == iv - w) ||
               ((ai | 65536) - bi == iv - w) ||
               ((bi | 65536) - ai == w);
    endfunction
endpackage

// File: rtl/bt_timer_slot.sv
module bt_timer_slot #(
    parameter int W    = 16,
    parameter int FRAC = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [15:0]  tu_now,
    input  logic [15:0]  ivl,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         fire
);
    logic [15:0]  cmp_tu;
    logic [W-1:0] step_w;
    logic         hit;

    assign cmp_tu = value[W-1:FRAC];
    assign step_w = W'(ivl) << FRAC;
    assign hit    = en && (cmp_tu == tu_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (load) begin
                value <= load_val;
            end else if (hit) begin
                value <= value + step_w;
                fire  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bt_window_check.sv
module bt_window_check
    import bt_pkg::*;
#(
    parameter int DMA_MARGIN = 2
) (
    input  logic [TU_W-1:0] nbt,
    input  logic [TU_W-1:0] dma_tu,
    input  logic [TU_W-1:0] atim,
    input  logic [TU_W-1:0] ivl,
    output logic            ok
);
    logic atim_ok, dma_ok;
    assign atim_ok = span_fits(nbt, atim, 1, ivl);
    assign dma_ok  = span_fits(dma_tu, nbt, DMA_MARGIN, ivl);
    assign ok      = atim_ok && dma_ok;
endmodule

// File: rtl/beacon_timer_set.sv
module beacon_timer_set
    import bt_pkg::*;
#(
    parameter int DMA_MARGIN = 2,
    parameter int SW_MARGIN  = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TU_W-1:0]     tu_now,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [ALERT_W-1:0]  wr_data,
    output logic [SLOTS-1:0]    fire,
    output logic [TU_W-1:0]     nbt_q,
    output logic [ALERT_W-1:0]  dma_q,
    output logic [ALERT_W-1:0]  swba_q,
    output logic [TU_W-1:0]     atim_q,
    output logic                window_ok
);
    logic [TU_W-1:0]    interval_q;
    logic               en_q;
    logic [TU_W-1:0]    nb_in;
    logic [TU_W-1:0]    arm_nbt, arm_atim;
    logic [ALERT_W-1:0] arm_dma, arm_sw;
    logic               arm;

    assign arm      = (wr_addr == AD_ARM);
    assign nb_in    = wr_data[TU_W-1:0];
    assign arm_nbt  = nb_in;
    assign arm_atim = nb_in + 16'd1;
    assign arm_dma  = {nb_in - 16'(DMA_MARGIN), {FRAC_W{1'b0}}};
    assign arm_sw   = {nb_in - 16'(SW_MARGIN), {FRAC_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q <= '0;
            en_q       <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == AD_IVL)  interval_q <= wr_data[TU_W-1:0];
            if (wr_addr == AD_CTRL) en_q       <= wr_data[0];
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam int FR = (i == SLOT_DMA || i == SLOT_SWBA) ? FRAC_W : 0;
        localparam int W  = TU_W + FR;
        logic [W-1:0] arm_w, ld_w, val_w;
        logic         ld;

        if (i == SLOT_NBT) begin : g_nbt
            assign arm_w = arm_nbt;
            assign nbt_q = val_w;
        end else if (i == SLOT_DMA) begin : g_dma
            assign arm_w = arm_dma;
            assign dma_q = val_w;
        end else if (i == SLOT_SWBA) begin : g_sw
            assign arm_w  = arm_sw;
            assign swba_q = val_w;
        end else begin : g_atim
            assign arm_w  = arm_atim;
            assign atim_q = val_w;
        end

        assign ld   = wr_en && (arm || wr_addr == 3'(i));
        assign ld_w = arm ? arm_w : W'(wr_data);

        bt_timer_slot #(.W(W), .FRAC(FR)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .en       (en_q),
            .tu_now   (tu_now),
            .ivl      (interval_q),
            .load     (ld),
            .load_val (ld_w),
            .value    (val_w),
            .fire     (fire[i])
        );
    end

    bt_window_check #(.DMA_MARGIN(DMA_MARGIN)) u_win (
        .nbt    (nbt_q),
        .dma_tu (dma_q[ALERT_W-1:FRAC_W]),
        .atim   (atim_q),
        .ivl    (interval_q),
        .ok     (window_ok)
    );
endmodule

// File: rtl/bt_timer_set_chk.sv
module bt_timer_set_chk
    import bt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [TU_W-1:0]    tu_now,
    input logic               wr_en,
    input logic [2:0]         wr_addr,
    input logic               en_q,
    input logic [TU_W-1:0]    interval_q,
    input logic [SLOTS-1:0]   fire,
    input logic [TU_W-1:0]    nbt_q,
    input logic [ALERT_W-1:0] dma_q,
    input logic [TU_W-1:0]    atim_q
);
    p_fire_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        (fire != 4'd0) |-> $past(en_q));

    p_nbt_match_r4: assert property (@(posedge clk) disable iff (rst)
        fire[0] |-> ($past(tu_now) == $past(nbt_q)));

    p_nbt_step_r5: assert property (@(posedge clk) disable iff (rst)
        fire[0] |-> (nbt_q == $past(nbt_q) + $past(interval_q)));

    p_dma_step_r5: assert property (@(posedge clk) disable iff (rst)
        fire[1] |-> (dma_q == $past(dma_q) + {$past(interval_q), 3'b000}));

    p_nbt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tu_now != nbt_q) |=> $stable(nbt_q));

    p_arm_atim_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AD_ARM) |=> (atim_q == nbt_q + 16'd1));
endmodule

bind beacon_timer_set bt_timer_set_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tu_now     (tu_now),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .en_q       (en_q),
    .interval_q (interval_q),
    .fire       (fire),
    .nbt_q      (nbt_q),
    .dma_q      (dma_q),
    .atim_q     (atim_q)
);

// File: tb/beacon_timer_set_test.sv
module beacon_timer_set_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] tu_now;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [18:0] wr_data;
    logic [3:0]  fire;
    logic [15:0] nbt_q, atim_q;
    logic [18:0] dma_q, swba_q;
    logic        window_ok;

    always #10 clk = ~clk;

    beacon_timer_set uut (
        .clk(clk), .rst(rst), .tu_now(tu_now), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fire(fire), .nbt_q(nbt_q), .dma_q(dma_q),
        .swba_q(swba_q), .atim_q(atim_q), .window_ok(window_ok)
    );

    int checks = 0;
    int errors = 0;
    int e[4];
    int iv;
    bit en;
    bit done = 0;

    function automatic bit is_alert(int i);
        return (i == 1 || i == 2);
    endfunction

    function automatic int msk(int i);
        return is_alert(i) ? 'h7FFFF : 'hFFFF;
    endfunction

    function automatic int arm_val(int i, int nb);
        case (i)
            0: return nb;
            1: return ((nb - 2) & 'hFFFF) << 3;
            2: return ((nb - 10) & 'hFFFF) << 3;
            default: return (nb + 1) & 'hFFFF;
        endcase
    endfunction

    function automatic bit win(int a, int b, int w, int ivl);
        return (b - a == w) || (a - b == ivl - w) ||
               ((a + 65536) - b == ivl - w) || ((b + 65536) - a == w);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int out_val(int i);
        case (i)
            0: return int'(nbt_q);
            1: return int'(dma_q);
            2: return int'(swba_q);
            default: return int'(atim_q);
        endcase
    endfunction

    // One clock: drive at falling edge, update model, sample at next falling edge
    task automatic cyc(int tu, bit we = 0, int addr = 0, int data = 0);
        int ef;
        string ft;
        ef = 0;
        ft = en ? "R4 fire" : "R6 fire while disabled";
        tu_now  = 16'(tu);
        wr_en   = we;
        wr_addr = 3'(addr);
        wr_data = 19'(data);
        for (int i = 0; i < 4; i++) begin
            if (we && (addr == i || addr == 6)) begin
                e[i] = (addr == 6) ? arm_val(i, data & 'hFFFF) : (data & msk(i));
            end else if (en && ((is_alert(i) ? (e[i] >> 3) : e[i]) == (tu & 'hFFFF))) begin
                ef |= (1 << i);
                e[i] = (e[i] + (is_alert(i) ? (iv << 3) : iv)) & msk(i);
            end
        end
        if (we && addr == 4) iv = data & 'hFFFF;
        if (we && addr == 5) en = ((data & 1) != 0);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk(ft, int'(fire), ef);
        for (int i = 0; i < 4; i++)
            chk(en ? "R5 timer value" : "R6 timer hold", out_val(i), e[i]);
        chk("R8 window flag", int'(window_ok),
            int'(win(e[0], e[3], 1, iv) && win(e[1] >> 3, e[0], 2, iv)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tu_now = 16'd0; wr_en = 1'b0; wr_addr = 3'd0; wr_data = 19'd0;
        for (int i = 0; i < 4; i++) e[i] = 0;
        iv = 0; en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 fire after reset", int'(fire), 0);
        chk("R1 nbt after reset", int'(nbt_q), 0);
        chk("R1 dma after reset", int'(dma_q), 0);
        chk("R1 atim after reset", int'(atim_q), 0);
        chk("R1 window after reset", int'(window_ok), 0);
        rst = 1'b0;

        cyc(60000, 1, 4, 50);
        cyc(60000, 1, 6, 100);
        chk("R3 arm nbt", int'(nbt_q), 100);
        chk("R3 arm dma", int'(dma_q), 784);
        chk("R3 arm swba", int'(swba_q), 720);
        chk("R3 arm atim", int'(atim_q), 101);
        chk("R9 window after arm", int'(window_ok), 1);
        cyc(60000, 1, 5, 1);

        for (int t = 0; t < 400; t++) cyc(t);

        // R7 jump past ATIM end
        cyc(400);
        cyc(405);
        cyc(450);
        chk("R7 stranded atim", int'(atim_q), 401);
        chk("R7 window stretched", int'(window_ok), 0);
        cyc(401);
        chk("R7 atim resumes", int'(atim_q), 451);

        // R2 write and match in the same cycle
        cyc(500, 1, 0, 1234);
        chk("R2 write wins nbt", int'(nbt_q), 1234);
        chk("R2 no nbt pulse", int'(fire[0]), 0);
        cyc(60000, 1, 2, 'h12345);
        chk("R2 swba direct write", int'(swba_q), 'h12345);

        // wrap of the TU count
        cyc(60000, 1, 6, 65530);
        for (int t = 65500; t < 65536; t++) cyc(t);
        for (int t = 0; t < 150; t++) cyc(t);

        // R6 disabled
        cyc(60000, 1, 5, 0);
        for (int t = 0; t < 600; t++) cyc(t);

        // R9 margins below zero and a broken ATIM window
        cyc(60000, 1, 6, 1);
        chk("R9 window with wrapped margin", int'(window_ok), 1);
        cyc(60000, 1, 3, 3);
        chk("R9 atim window off by one", int'(window_ok), 0);

        // R8 third acceptance case
        cyc(60000, 1, 4, 57);
        cyc(60000, 1, 0, 20);
        cyc(60000, 1, 1, 144);
        cyc(60000, 1, 3, 65500);
        chk("R8 wrapped lead case", int'(window_ok), 1);
        cyc(60000, 1, 3, 65501);
        chk("R8 wrapped lead mismatch", int'(window_ok), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule